// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit counting channel of a programmable interval timer. It counts on a clock-enable tick rather than on its own clock. A mode code picks one of six behaviours for the OUT pin: a one-shot level, a one-tick strobe, a rate pulse or a square wave. The same code also decides whether the gate input pauses counting or restarts it. Counting is binary only. The count value comes in through a load strobe. The tick after the load applies the value, and from then on the count is measured as the number of ticks elapsed since that restart.

Load, mode and gate are plain control pins with no handshake. A load strobe is always accepted and never back-pressured. A second strobe issued before the next tick replaces the pending value. The current count and OUT are driven from registers and are valid in every cycle.

Top module: `interval_counter_ch`

## Requirements
- R1: After reset, and until the first mode write, OUT is low and count reads 0, whatever happens on tick_en, gate or load_stb.
- R2: A load value of 0 acts as 65536. In mode 0, OUT stays low for 65535 ticks after the load is applied and goes high on tick 65536.
- R3: A load strobe has no visible effect until the next tick_en cycle. That tick sets count to the new value and restarts the elapsed count at 0 without decrementing. Count changes only on tick_en cycles, on a mode write, or on a restart caused by the gate.
- R4: Mode 0: after the load, OUT is low. OUT goes high once the elapsed ticks reach N and stays high. While gate is low, ticks are ignored.
- R5: Mode 1: OUT is low while the elapsed ticks are fewer than N and high afterwards. A rising gate edge restarts the elapsed count at 0 and drives OUT low in the next cycle.
- R6: Mode 2: count reads N minus (elapsed mod N), and the channel reloads by itself. OUT is high exactly when the elapsed ticks are a nonzero multiple of N.
- R7: Mode 3: count reads N minus ((2 x elapsed) mod N), so it falls by two per tick. OUT is high while (elapsed mod N) is less than (N+1)/2, and low for the rest of the period. This holds for odd N too.
- R8: Modes 4 and 5: OUT is high only while the elapsed ticks equal N. The strobe is therefore one tick long, and the next tick drops it.
- R9: In modes 0, 1, 4 and 5, count falls by one per counted tick and wraps from 0 to 65535.
- R10: In modes 1, 2, 3 and 5, a rising gate edge restarts counting from N, and the gate level has no other effect. In modes 0 and 4, the gate level only enables or disables counting, and a rising edge does not restart.
- R11: Mode codes are mode_sel values 0 to 5. The codes 6 and 7 behave as 2 and 3.
- R12: A mode write restarts the elapsed count at 0 and sets count to the current N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable; one counting step per asserted cycle |
| mode_we | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code captured on mode_we |
| load_stb | input | 1 | Count load strobe |
| load_val | input | 16 | Count value; 0 means 65536 |
| gate | input | 1 | Gate input (enable or retrigger, depending on mode) |
| count | output | 16 | Current readable count |
| out | output | 1 | Timer output waveform |

## Verification
A wrong elapsed-phase value shows up on count one clock after the tick that produces it. The error appears at once in modes 2 and 3, where count is taken directly from the phase. In the one-shot modes, a wrong wrap state is hidden until the terminal tick, where OUT rises early, rises late or fails to fall. Those cases are therefore checked exactly at N-1, N and N+1 ticks. A gate edge that is decoded wrongly changes count in the cycle right after the edge, so the restart and pause cases are sampled there.

// File: rtl/ict_pkg.sv
package ict_pkg;
  typedef enum logic [2:0] {
    MD_ONESHOT  = 3'd0,
    MD_RETRIG   = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ict_mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic ict_mode_e fold_mode(input logic [2:0] code);
    return (code > 3'd5) ? ict_mode_e'(code - 3'd4) : ict_mode_e'(code);
  endfunction

  // modes in which a rising gate edge restarts the count
  function automatic logic edge_restarts(input ict_mode_e m);
    return (m == MD_RETRIG) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTROBE);
  endfunction

  // modes in which the gate level holds counting
  function automatic logic level_holds(input ict_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_SWSTROBE);
  endfunction
endpackage

// File: rtl/ict_ctrl.sv
module ict_ctrl
  import ict_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mode_we,
  input  logic [2:0]       mode_sel,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             gate,
  output ict_mode_e        mode_q,
  output logic             cfg_valid,
  output logic [PH_W-1:0]  n_q,
  output logic [PH_W-1:0]  load_n,
  output logic             ld_apply,
  output logic             restart,
  output logic             run_en
);
  localparam logic [PH_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic             pend_q;
  logic [CNT_W-1:0] pend_val_q;
  logic             gate_q;
  logic             gate_rise;

  assign gate_rise = gate & ~gate_q;
  assign load_n    = (pend_val_q == '0) ? FULL : {1'b0, pend_val_q};
  assign ld_apply  = tick_en & pend_q & cfg_valid & ~mode_we;
  assign restart   = mode_we | (cfg_valid & gate_rise & edge_restarts(mode_q));
  assign run_en    = cfg_valid & tick_en & ~ld_apply & ~restart
                   & (gate | ~level_holds(mode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MD_ONESHOT;
      cfg_valid  <= 1'b0;
      n_q        <= FULL;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      gate_q     <= 1'b0;
    end else begin
      gate_q <= gate;
      if (mode_we) begin
        mode_q    <= fold_mode(mode_sel);
        cfg_valid <= 1'b1;
      end
      if (ld_apply) n_q <= load_n;
      if (load_stb) begin
        pend_q     <= 1'b1;
        pend_val_q <= load_val;
      end else if (ld_apply) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ict_phase.sv
module ict_phase #(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  n_q,
  input  logic [PH_W-1:0]  load_n,
  input  logic             ld_apply,
  input  logic             restart,
  input  logic             run_en,
  output logic [PH_W-1:0]  phase,
  output logic [1:0]       wraps,
  output logic [CNT_W-1:0] cnt
);
  logic [PH_W-1:0] phase_inc;
  logic            period_end;

  assign phase_inc  = phase + 1'b1;
  assign period_end = (phase_inc == n_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      wraps <= 2'd0;
      cnt   <= '0;
    end else if (ld_apply) begin
      phase <= '0;
      wraps <= 2'd0;
      cnt   <= load_n[CNT_W-1:0];
    end else if (restart) begin
      phase <= '0;
      wraps <= 2'd0;
      cnt   <= n_q[CNT_W-1:0];
    end else if (run_en) begin
      cnt <= cnt - 1'b1;
      if (period_end) begin
        phase <= '0;
        if (wraps != 2'd2) wraps <= wraps + 2'd1;
      end else begin
        phase <= phase_inc;
      end
    end
  end
endmodule

// File: rtl/ict_decode.sv
module ict_decode
  import ict_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  ict_mode_e        mode_q,
  input  logic             cfg_valid,
  input  logic [PH_W-1:0]  n_q,
  input  logic [PH_W-1:0]  phase,
  input  logic [1:0]       wraps,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] count,
  output logic             out
);
  logic [PH_W-1:0]  half;
  logic             first_half;
  logic             reached;
  logic             exact;
  logic [CNT_W-1:0] n_lo;
  logic [CNT_W-1:0] p_lo;
  logic [CNT_W-1:0] p_dbl;

  assign half       = (n_q + 1'b1) >> 1;
  assign first_half = (phase < half);
  assign reached    = (wraps != 2'd0);
  assign exact      = (wraps == 2'd1) && (phase == '0);
  assign n_lo       = n_q[CNT_W-1:0];
  assign p_lo       = phase[CNT_W-1:0];
  assign p_dbl      = {p_lo[CNT_W-2:0], 1'b0};

  always_comb begin
    count = cnt;
    out   = 1'b0;
    unique case (mode_q)
      MD_ONESHOT, MD_RETRIG: out = reached;
      MD_RATE: begin
        count = n_lo - p_lo;
        out   = reached && (phase == '0);
      end
      MD_SQUARE: begin
        count = first_half ? (n_lo - p_dbl) : ({n_lo[CNT_W-2:0], 1'b0} - p_dbl);
        out   = first_half;
      end
      MD_SWSTROBE, MD_HWSTROBE: out = exact;
      default: out = 1'b0;
    endcase
    if (!cfg_valid) out = 1'b0;
  end
endmodule

// File: rtl/interval_counter_ch.sv
module interval_counter_ch
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mode_we,
  input  logic [2:0]       mode_sel,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             gate,
  output logic [CNT_W-1:0] count,
  output logic             out
);
  localparam int PH_W = CNT_W + 1;

  ict_mode_e        mode_q;
  logic             cfg_valid;
  logic [PH_W-1:0]  n_q;
  logic [PH_W-1:0]  load_n;
  logic             ld_apply;
  logic             restart;
  logic             run_en;
  logic [PH_W-1:0]  phase;
  logic [1:0]       wraps;
  logic [CNT_W-1:0] cnt;

  ict_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_we(mode_we),
    .mode_sel(mode_sel), .load_stb(load_stb), .load_val(load_val), .gate(gate),
    .mode_q(mode_q), .cfg_valid(cfg_valid), .n_q(n_q), .load_n(load_n),
    .ld_apply(ld_apply), .restart(restart), .run_en(run_en)
  );

  ict_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .n_q(n_q), .load_n(load_n), .ld_apply(ld_apply),
    .restart(restart), .run_en(run_en), .phase(phase), .wraps(wraps), .cnt(cnt)
  );

  ict_decode #(.CNT_W(CNT_W)) u_decode (
    .mode_q(mode_q), .cfg_valid(cfg_valid), .n_q(n_q), .phase(phase),
    .wraps(wraps), .cnt(cnt), .count(count), .out(out)
  );
endmodule

// File: rtl/ict_checker.sv
module ict_checker
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             mode_we,
  input logic             gate,
  input logic [CNT_W-1:0] count,
  input logic             out,
  input ict_mode_e        mode_q,
  input logic             ld_apply,
  input logic             restart,
  input logic             run_en
);
  logic seen_mode;
  logic gate_prev;
  logic gate_up;
  logic one_step;

  assign gate_up  = gate & ~gate_prev;
  assign one_step = run_en && (mode_q == MD_ONESHOT || mode_q == MD_RETRIG ||
                               mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_mode <= 1'b0;
      gate_prev <= 1'b0;
    end else begin
      gate_prev <= gate;
      if (mode_we) seen_mode <= 1'b1;
    end
  end

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_mode |-> !out); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !mode_we && !gate_up) |=> $stable(count)); // R3

  AST_ONESHOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && out && !mode_we && !ld_apply) |=> out); // R4

  AST_RETRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !mode_we && mode_q == MD_RETRIG) |=> !out); // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE) && out && run_en) |=> !out); // R8

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    one_step |=> (count == CNT_W'($past(count) - 1'b1))); // R9
endmodule

bind interval_counter_ch ict_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_we(mode_we), .gate(gate),
  .count(count), .out(out), .mode_q(mode_q), .ld_apply(ld_apply),
  .restart(restart), .run_en(run_en)
);

// File: tb/sim_interval_counter_ch.sv
module sim_interval_counter_ch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        mode_we;
  logic [2:0]  mode_sel;
  logic        load_stb;
  logic [15:0] load_val;
  logic        gate;
  logic [15:0] count;
  logic        out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  interval_counter_ch u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_we(mode_we),
    .mode_sel(mode_sel), .load_stb(load_stb), .load_val(load_val), .gate(gate),
    .count(count), .out(out)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] nval;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_out;
  } row_t;

  localparam int NROWS = 20;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0, 16'd5, 8'd3, 16'd2,     1'b0},  // R4
    '{3'd0, 16'd5, 8'd5, 16'd0,     1'b1},  // R4
    '{3'd0, 16'd5, 8'd7, 16'hFFFE,  1'b1},  // R9 wrap
    '{3'd1, 16'd4, 8'd2, 16'd2,     1'b0},  // R5
    '{3'd1, 16'd4, 8'd6, 16'hFFFE,  1'b1},  // R5 R9
    '{3'd2, 16'd4, 8'd0, 16'd4,     1'b0},  // R6
    '{3'd2, 16'd4, 8'd4, 16'd4,     1'b1},  // R6
    '{3'd2, 16'd4, 8'd5, 16'd3,     1'b0},  // R6
    '{3'd2, 16'd4, 8'd8, 16'd4,     1'b1},  // R6
    '{3'd3, 16'd6, 8'd2, 16'd2,     1'b1},  // R7
    '{3'd3, 16'd6, 8'd3, 16'd6,     1'b0},  // R7
    '{3'd3, 16'd5, 8'd2, 16'd1,     1'b1},  // R7 odd
    '{3'd3, 16'd5, 8'd3, 16'd4,     1'b0},  // R7 odd
    '{3'd4, 16'd3, 8'd3, 16'd0,     1'b1},  // R8
    '{3'd4, 16'd3, 8'd4, 16'hFFFF,  1'b0},  // R8 R9
    '{3'd5, 16'd3, 8'd2, 16'd1,     1'b0},  // R8
    '{3'd6, 16'd4, 8'd4, 16'd4,     1'b1},  // R11 as rate
    '{3'd7, 16'd6, 8'd1, 16'd4,     1'b1},  // R11 as square
    '{3'd2, 16'd0, 8'd1, 16'hFFFF,  1'b0},  // R2 zero as 65536
    '{3'd3, 16'd1, 8'd5, 16'd1,     1'b1}   // R7 N=1
  };

  function automatic string row_req(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_sel = m;
    mode_we  = 1'b1;
    @(negedge clk);
    mode_we  = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    load_val = v;
    load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; mode_we = 1'b0; mode_sel = 3'd0;
    load_stb = 1'b0; load_val = 16'd0; gate = 1'b1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, then stimulus without any mode write
    chk("R1", "reset count", count, 0);
    chk("R1", "reset out", out, 0);
    load(16'd7);
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
    ticks(4);
    chk("R1", "idle count", count, 0);
    chk("R1", "idle out", out, 0);

    // R3: a load waits for the next tick; no tick, no change
    set_mode(3'd0);
    load(16'd10);
    chk("R3", "before tick", count, 0);
    idle(2);
    chk("R3", "still before tick", count, 0);
    ticks(1);
    chk("R3", "applied", count, 10);
    idle(3);
    chk("R3", "no tick hold", count, 10);
    ticks(1);
    chk("R3", "one tick", count, 9);

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      set_mode(ROWS[r].mode);
      load(ROWS[r].nval);
      ticks(1);
      ticks(int'(ROWS[r].ticks));
      chk(row_req(ROWS[r].mode), $sformatf("row %0d count", r), count, ROWS[r].exp_cnt);
      chk(row_req(ROWS[r].mode), $sformatf("row %0d out", r), out, ROWS[r].exp_out);
    end

    // R4 R10: mode 0 gate low pauses; rising edge does not restart
    set_mode(3'd0); load(16'd5); ticks(1); ticks(2);
    chk("R4", "mode0 before pause", count, 3);
    gate = 1'b0; @(negedge clk);
    ticks(3);
    chk("R10", "mode0 paused", count, 3);
    gate = 1'b1; @(negedge clk);
    chk("R10", "mode0 no restart on edge", count, 3);
    ticks(1);
    chk("R4", "mode0 resumed", count, 2);

    // R5 R10: mode 1 retrigger
    set_mode(3'd1); load(16'd4); ticks(1); ticks(5);
    chk("R5", "mode1 past terminal out", out, 1);
    gate = 1'b0; @(negedge clk);
    ticks(1);
    chk("R10", "mode1 gate level ignored", count, 16'hFFFE);
    gate = 1'b1; @(negedge clk);
    chk("R5", "mode1 restart count", count, 4);
    chk("R5", "mode1 restart out", out, 0);

    // R8 R10: mode 5 strobe after gate trigger
    set_mode(3'd5); load(16'd3); ticks(1); ticks(1);
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
    chk("R10", "mode5 restart", count, 3);
    ticks(2);
    chk("R8", "mode5 before strobe", out, 0);
    ticks(1);
    chk("R8", "mode5 strobe", out, 1);
    idle(2);
    chk("R8", "mode5 strobe held w/o tick", out, 1);
    ticks(1);
    chk("R8", "mode5 strobe ends", out, 0);

    // R6 R10: mode 2 gate edge restart
    set_mode(3'd2); load(16'd4); ticks(1); ticks(2);
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
    chk("R10", "mode2 restart", count, 4);

    // R12: mode write restarts from current N
    set_mode(3'd2); load(16'd9); ticks(1); ticks(3);
    chk("R12", "before rewrite", count, 6);
    set_mode(3'd2);
    chk("R12", "after rewrite", count, 9);

    // R2: zero load in mode 0 runs for 65536 ticks
    set_mode(3'd0); load(16'd0); ticks(1);
    chk("R2", "zero load count", count, 0);
    ticks(65535);
    chk("R2", "tick 65535 out", out, 0);
    chk("R2", "tick 65535 count", count, 1);
    ticks(1);
    chk("R2", "tick 65536 out", out, 1);
    chk("R2", "tick 65536 count", count, 0);

    finish_run();
  end
endmodule